// File: doc/BRIEF.md
# Telemetry Vector Message Serializer

This block puts one measurement message onto a single-bit serial telemetry line each time a send trigger arrives. The message carries three signed vector components (X, Y, Z). Each component is sign-extended to twice the word width and split into a most significant word and a least significant word, so the message carries six words. A run of zero bits opens the message. Each word follows its own start bit of value 1. A single zero in the slot where a seventh start bit would fall closes the message.

The line advances by one bit on every rising edge of the bit clock, so a receiver that samples on the falling edge sees stable data. The component inputs are captured when the trigger is accepted, so the source may change them freely while the message is on the line. The delay from the trigger to the first line bit is fixed. The same block serves both a fixed high-rate channel and a commanded low-rate channel; only the trigger source differs.

Top module: `tlm_vec_ser`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `tlm_line` and `tlm_busy` are 0.
- R2: With no trigger, `tlm_line` stays 0 and `tlm_busy` stays 0.
- R3: A trigger sampled high on a rising edge while `tlm_busy` is 0 is accepted. `tlm_busy` stays 0 in the cycle after that edge and goes to 1 on the following edge, together with bit 0 of the message. The message opens with PRE_LEN (17) zero bits.
- R4: Each word is sent as a start bit of 1 followed by its WORD_W (16) bits, most significant bit first. Each bit is held for exactly one clock cycle.
- R5: The six words go out in this order: X upper, X lower, Y upper, Y lower, Z upper, Z lower. The upper word is bits 31..16 of the sign-extended component: eight copies of bit 23 followed by bits 23..16. The lower word is bits 15..0.
- R6: Right after the last bit of the Z lower word, one 0 end bit is sent. When `tlm_busy` is 0, `tlm_line` is 0.
- R7: `tlm_busy` is high for exactly 120 consecutive cycles per message: 17 + 6×17 + 1.
- R8: The components are captured on the edge that accepts the trigger. Changes on `vec_x`, `vec_y` and `vec_z` after that edge do not alter the message.
- R9: A trigger sampled while `tlm_busy` is 1 is ignored, including in the last busy cycle. After such a trigger, no further message starts and the line stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; the line changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| send | input | 1 | Trigger to start one message |
| vec_x | input | COMP_W (24) | Signed X component |
| vec_y | input | COMP_W (24) | Signed Y component |
| vec_z | input | COMP_W (24) | Signed Z component |
| tlm_line | output | 1 | Serial telemetry line, registered |
| tlm_busy | output | 1 | High for every bit period of a message, registered |

## Verification
The bench builds the block with its default parameters: 24-bit components, 16-bit words and a 17-bit preamble. These values make the sign-fill byte in each upper word visible and give a message of 120 bits, so the captured stream can be compared field by field against a model built in the bench. Mixed-sign and all-ones component values exercise the sign extension. Triggers in the middle of a message and in its final busy cycle probe the point where a trigger stops being ignored, and a back-to-back message shows that the next trigger is taken once busy falls.

// File: rtl/tlm_pkg.sv
`timescale 1ns/1ps
package tlm_pkg;
  localparam int TLM_AXES = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_WORD,
    ST_END
  } tlm_state_e;
endpackage

// File: rtl/tlm_capture.sv
`timescale 1ns/1ps
module tlm_capture #(
  parameter int COMP_W = 24,
  parameter int WORD_W = 16,
  parameter int AXES   = 3,
  localparam int EXT_W = 2 * WORD_W,
  localparam int NW    = 2 * AXES
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [AXES*COMP_W-1:0] comp_flat,
  output logic [NW*WORD_W-1:0]   words_flat
);
  logic [COMP_W-1:0] comp_q [AXES];

  for (genvar c = 0; c < AXES; c++) begin : g_axis
    logic [EXT_W-1:0] ext;

    always_ff @(posedge clk) begin
      if (rst) begin
        comp_q[c] <= '0;
      end else if (load) begin
        comp_q[c] <= comp_flat[c*COMP_W +: COMP_W];
      end
    end

    always_comb begin
      ext = {{(EXT_W-COMP_W){comp_q[c][COMP_W-1]}}, comp_q[c]};
    end

    assign words_flat[(2*c)*WORD_W   +: WORD_W] = ext[EXT_W-1 -: WORD_W];
    assign words_flat[(2*c+1)*WORD_W +: WORD_W] = ext[WORD_W-1:0];
  end
endmodule

// File: rtl/tlm_frame_seq.sv
`timescale 1ns/1ps
module tlm_frame_seq
  import tlm_pkg::*;
#(
  parameter int PRE_LEN = 17,
  parameter int WORD_W  = 16,
  parameter int NW      = 6,
  localparam int PCW    = $clog2(PRE_LEN),
  localparam int SCW    = $clog2(WORD_W + 1),
  localparam int WCW    = $clog2(NW)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_req,
  output logic           accept,
  output tlm_state_e     st,
  output logic [WCW-1:0] widx,
  output logic [SCW-1:0] slot
);
  logic [PCW-1:0] pre_cnt;

  assign accept = (st == ST_IDLE) && start_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      pre_cnt <= '0;
      slot    <= '0;
      widx    <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (accept) begin
            st      <= ST_PRE;
            pre_cnt <= '0;
          end
        end
        ST_PRE: begin
          if (pre_cnt == PCW'(PRE_LEN - 1)) begin
            st   <= ST_WORD;
            slot <= '0;
            widx <= '0;
          end else begin
            pre_cnt <= pre_cnt + 1'b1;
          end
        end
        ST_WORD: begin
          if (slot == SCW'(WORD_W)) begin
            slot <= '0;
            if (widx == WCW'(NW - 1)) begin
              st <= ST_END;
            end else begin
              widx <= widx + 1'b1;
            end
          end else begin
            slot <= slot + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9
  pre_only_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |=> (st != ST_PRE) || ($past(st) == ST_PRE));

  // R5
  word_index_range_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WORD) |-> (int'(widx) < NW) && (int'(slot) <= WORD_W));
endmodule

// File: rtl/tlm_bit_pick.sv
`timescale 1ns/1ps
module tlm_bit_pick #(
  parameter int WORD_W = 16,
  parameter int NW     = 6,
  localparam int SCW   = $clog2(WORD_W + 1),
  localparam int WCW   = $clog2(NW),
  localparam int BW    = $clog2(WORD_W)
) (
  input  logic [NW*WORD_W-1:0] words_flat,
  input  logic [WCW-1:0]       widx,
  input  logic [SCW-1:0]       slot,
  input  logic                 in_word,
  output logic                 bit_out
);
  logic [WORD_W-1:0] cur;
  logic [BW-1:0]     bpos;

  always_comb begin
    cur  = words_flat[int'(widx)*WORD_W +: WORD_W];
    bpos = BW'(WORD_W - int'(slot));
    if (!in_word) begin
      bit_out = 1'b0;
    end else if (slot == '0) begin
      bit_out = 1'b1;
    end else begin
      bit_out = cur[bpos];
    end
  end
endmodule

// File: rtl/tlm_vec_ser.sv
`timescale 1ns/1ps
module tlm_vec_ser
  import tlm_pkg::*;
#(
  parameter int COMP_W  = 24,
  parameter int WORD_W  = 16,
  parameter int PRE_LEN = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              send,
  input  logic [COMP_W-1:0] vec_x,
  input  logic [COMP_W-1:0] vec_y,
  input  logic [COMP_W-1:0] vec_z,
  output logic              tlm_line,
  output logic              tlm_busy
);
  localparam int NW      = 2 * TLM_AXES;
  localparam int MSG_LEN = PRE_LEN + NW * (WORD_W + 1) + 1;
  localparam int SCW     = $clog2(WORD_W + 1);
  localparam int WCW     = $clog2(NW);
  localparam int RCW     = $clog2(MSG_LEN + 1) + 1;

  logic                  accept;
  tlm_state_e            st;
  logic [WCW-1:0]        widx;
  logic [SCW-1:0]        slot;
  logic [NW*WORD_W-1:0]  words_flat;
  logic                  bit_now;

  tlm_frame_seq #(.PRE_LEN(PRE_LEN), .WORD_W(WORD_W), .NW(NW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_req (send && !tlm_busy),
    .accept    (accept),
    .st        (st),
    .widx      (widx),
    .slot      (slot)
  );

  tlm_capture #(.COMP_W(COMP_W), .WORD_W(WORD_W), .AXES(TLM_AXES)) u_cap (
    .clk        (clk),
    .rst        (rst),
    .load       (accept),
    .comp_flat  ({vec_z, vec_y, vec_x}),
    .words_flat (words_flat)
  );

  tlm_bit_pick #(.WORD_W(WORD_W), .NW(NW)) u_pick (
    .words_flat (words_flat),
    .widx       (widx),
    .slot       (slot),
    .in_word    (st == ST_WORD),
    .bit_out    (bit_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tlm_line <= 1'b0;
      tlm_busy <= 1'b0;
    end else begin
      tlm_line <= bit_now;
      tlm_busy <= (st != ST_IDLE);
    end
  end

  logic [RCW-1:0] busy_run;
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_run <= '0;
    end else begin
      busy_run <= tlm_busy ? busy_run + 1'b1 : '0;
    end
  end

  // R7
  busy_length_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tlm_busy) |-> (busy_run == RCW'(MSG_LEN)));

  // R6
  idle_line_low_chk: assert property (@(posedge clk) disable iff (rst)
    !tlm_busy |-> !tlm_line);

  // R8
  words_held_chk: assert property (@(posedge clk) disable iff (rst)
    (tlm_busy && $past(tlm_busy)) |-> $stable(words_flat));

  // R9
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    tlm_busy |-> !accept);
endmodule

// File: tb/tlm_vec_ser_test.sv
`timescale 1ns/1ps
module tlm_vec_ser_test;
  localparam int MSG = 120;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        send = 1'b0;
  logic [23:0] vx = '0, vy = '0, vz = '0;
  logic        tlm_line, tlm_busy;

  int n_chk = 0;
  int n_fail = 0;
  logic cap [MSG];

  always #2.5 clk = ~clk;

  tlm_vec_ser uut (
    .clk(clk), .rst(rst), .send(send),
    .vec_x(vx), .vec_y(vy), .vec_z(vz),
    .tlm_line(tlm_line), .tlm_busy(tlm_busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input logic [23:0] x, y, z, input int w);
    logic [23:0] c;
    c = (w < 2) ? x : (w < 4) ? y : z;
    return (w % 2 == 0) ? {{8{c[23]}}, c[23:16]} : c[15:0];
  endfunction

  task automatic run_msg(input string tag, input logic [23:0] x, y, z,
                         input bit wiggle, input bit poke, input int idle_n);
    bit busy_all;
    bit pre_ok;
    logic [16:0] got;
    bit quiet;
    @(negedge clk);
    vx = x; vy = y; vz = z;
    send = 1'b1;
    @(negedge clk);
    send = 1'b0;
    check(!tlm_busy && !tlm_line, "R3", {tag, " latency cycle"}, {tlm_busy, tlm_line}, 0);
    busy_all = 1'b1;
    for (int p = 0; p < MSG; p++) begin
      @(negedge clk);
      cap[p] = tlm_line;
      busy_all &= tlm_busy;
      if (wiggle) begin
        vx = 24'($urandom); vy = 24'($urandom); vz = 24'($urandom);
      end
      send = poke && (p == 40 || p == MSG - 1);
    end
    @(negedge clk);
    send = 1'b0;
    check(busy_all, "R7", {tag, " busy held"}, busy_all, 1);
    check(!tlm_busy && !tlm_line, "R7", {tag, " busy falls after 120"}, {tlm_busy, tlm_line}, 0);
    pre_ok = 1'b1;
    for (int p = 0; p < 17; p++) pre_ok &= (cap[p] == 1'b0);
    check(pre_ok, "R3", {tag, " preamble zeros"}, pre_ok, 1);
    for (int w = 0; w < 6; w++) begin
      for (int b = 0; b < 17; b++) got[16-b] = cap[17 + w*17 + b];
      check(got == {1'b1, exp_word(x, y, z, w)}, "R5",
            $sformatf("%s word %0d (R4 start bit, msb first)", tag, w),
            got, {1'b1, exp_word(x, y, z, w)});
    end
    check(cap[MSG-1] == 1'b0, "R6", {tag, " end bit"}, cap[MSG-1], 0);
    quiet = 1'b1;
    for (int i = 0; i < idle_n; i++) begin
      @(negedge clk);
      quiet &= !tlm_line && !tlm_busy;
    end
    if (idle_n > 0)
      check(quiet, poke ? "R9" : "R2", {tag, " line quiet after message"}, quiet, 1);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    send = 1'b1;
    repeat (4) @(negedge clk);
    check(!tlm_line && !tlm_busy, "R1", "during reset", {tlm_line, tlm_busy}, 0);
    send = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check(!tlm_line && !tlm_busy, "R1", "after release", {tlm_line, tlm_busy}, 0);
  endtask

  task automatic t_idle;
    bit quiet = 1'b1;
    vx = 24'hFFFFFF; vy = 24'hFFFFFF; vz = 24'hFFFFFF;
    repeat (30) begin
      @(negedge clk);
      quiet &= !tlm_line && !tlm_busy;
    end
    check(quiet, "R2", "no trigger keeps line idle", quiet, 1);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    run_msg("positive", 24'h123456, 24'h0A5A5A, 24'h7FFFFF, 1'b0, 1'b0, 10);
    run_msg("negative", 24'h800001, 24'hFEDCBA, 24'hFFFFFF, 1'b0, 1'b0, 10);
    run_msg("latched R8", 24'hC3A5F0, 24'h00FF00, 24'h800000, 1'b1, 1'b0, 5);
    run_msg("busy trig", 24'h5AA5C3, 24'h9F0001, 24'h000000, 1'b0, 1'b1, 40);
    run_msg("back1", 24'h000001, 24'hFFFFFE, 24'h400000, 1'b0, 1'b0, 0);
    run_msg("back2 R9", 24'hBCDEF0, 24'h135790, 24'h876543, 1'b0, 1'b0, 10);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule